// File: doc/BRIEF.md
# Timer/Counter with Post-Write Compare Suppression

This block is a free-running up-counter with two compare channels and a wrap flag, clocked entirely from the system clock. A prescaler produces a single-cycle advance pulse: every cycle, once every eighth cycle, or never. On each advance the counter steps up by one and rolls from its all-ones value back to zero. Each compare channel holds a register that software writes. On an advance, the channel raises a sticky flag if the counter value present during that advance equals its register.

Software reaches the block through a single write port. Through it, software loads the counter, loads either compare register, or clears flags by writing ones. A load of the counter disarms compare detection for the next advance pulse, however long that takes to arrive. Software can therefore park the counter on a compare value without producing a false event.

Top module: `cmp_timer`

## Requirements
- R1: After synchronous reset the counter reads 0 and all three flags read 0.
- R2: With `clk_sel` = 0 the counter holds its value and no flag is set by counting.
- R3: With `clk_sel` = 1 the counter advances by one on every rising clock edge.
- R4: With `clk_sel` = 2 or 3 the counter advances once per 8 edges. Any change of `clk_sel` restarts the prescale count, so after a switch into divide-by-8 the first advance happens on the ninth rising edge at which the new value is applied.
- R5: An advance taken while the counter is all ones sets it to 0 and sets `flags_o[0]` (wrap flag) on that same edge.
- R6: An advance taken while the counter equals compare register A (`wr_addr` = 1) sets `flags_o[1]`, and one taken while it equals register B (`wr_addr` = 2) sets `flags_o[2]`. The flag appears on the edge that moves the counter past the matching value.
- R7: A write with `wr_addr` = 0 loads `wr_data` into the counter on that edge. Any advance in the same cycle is discarded, and that cycle makes no compare and no wrap.
- R8: The first advance after a counter load performs no compare on either channel, so a loaded value equal to a compare register never sets its flag. Only that single advance is suppressed.
- R9: The suppression stays armed while the timer is stopped and is consumed by the first advance that follows, whatever the prescale setting.
- R10: A write with `wr_addr` = 3 clears every flag whose bit in `wr_data[2:0]` is 1 and leaves the others unchanged. If a flag is set in the same cycle as its clear, it ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Advance rate: 0 stop, 1 every cycle, 2/3 every 8 cycles |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write target: 0 counter, 1 compare A, 2 compare B, 3 flag clear |
| wr_data | input | WIDTH | Write data |
| count_o | output | WIDTH | Current counter value |
| flags_o | output | 3 | Sticky flags: bit 0 wrap, bit 1 compare A, bit 2 compare B |

## Verification
Several properties are checked on every cycle by assertions. A stalled counter holds its value, and a load is taken exactly. The all-ones value rolls to zero, and the wrap flag rises only there. A prescaled advance is never followed directly by another. An armed suppression survives idle cycles, and no compare flag rises on a suppressed advance. Set-over-clear priority is checked the same way. Only the bench's scenarios can show the exact edge on which the first divide-by-8 advance lands after a rate change. They also show that a match is missed when the loaded value equals a compare register, and that the match returns on the advance after.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CS_STOP  = 2'd0,
        CS_DIV1  = 2'd1,
        CS_DIVN  = 2'd2,
        CS_DIVN2 = 2'd3
    } clk_sel_e;

    typedef enum logic [1:0] {
        WA_COUNT = 2'd0,
        WA_CMP_A = 2'd1,
        WA_CMP_B = 2'd2,
        WA_FLAGS = 2'd3
    } wr_addr_e;

    localparam int NUM_CH    = 2;
    localparam int NUM_FLAGS = NUM_CH + 1;
    localparam int FLG_WRAP  = 0;

    typedef struct packed {
        logic              load_cnt;
        logic [NUM_CH-1:0] load_cmp;
        logic              clr;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic en, input logic [1:0] addr);
        wr_dec_t d;
        d.load_cnt    = en && (addr == WA_COUNT);
        d.load_cmp[0] = en && (addr == WA_CMP_A);
        d.load_cmp[1] = en && (addr == WA_CMP_B);
        d.clr         = en && (addr == WA_FLAGS);
        return d;
    endfunction

    function automatic logic sel_divided(input logic [1:0] sel);
        return sel[1];
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    output logic       tick_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;
    logic [1:0]    sel_q;
    logic          chg;

    assign chg = (sel != sel_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            sel_q <= CS_STOP;
        end else begin
            sel_q <= sel;
            if (chg || !sel_divided(sel) || pre_q == LAST)
                pre_q <= '0;
            else
                pre_q <= pre_q + 1'b1;
        end
    end

    always_comb begin
        case (sel)
            CS_STOP: tick_o = 1'b0;
            CS_DIV1: tick_o = 1'b1;
            default: tick_o = !chg && (pre_q == LAST);
        endcase
    end

    AST_DIV_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick_o && sel_divided(sel)) |=> (!tick_o || !sel_divided(sel))); // R4

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o,
    output logic         cmp_en_o,
    output logic         blocked_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         blk_q;
    logic         adv;

    assign adv = tick && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            blk_q <= 1'b0;
        end else begin
            if (load)
                cnt_q <= load_val;
            else if (tick)
                cnt_q <= cnt_q + 1'b1;
            if (load)
                blk_q <= 1'b1;
            else if (tick)
                blk_q <= 1'b0;
        end
    end

    assign cnt_o     = cnt_q;
    assign blocked_o = blk_q;
    assign wrap_o    = adv && (cnt_q == MAXV);
    assign cmp_en_o  = adv && !blk_q;

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_o)); // R2
    AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_o == $past(load_val))); // R7
    AST_ROLL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt_o == MAXV) |=> (cnt_o == '0)); // R5
    AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        (blocked_o && !tick) |=> blocked_o); // R9

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cnt,
    input  logic         cmp_en,
    output logic         match_o
);
    logic [W-1:0] ref_q;

    always_ff @(posedge clk) begin
        if (rst)
            ref_q <= '0;
        else if (load)
            ref_q <= load_val;
    end

    assign match_o = cmp_en && (cnt == ref_q);

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_en,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flg_q;
    logic [N-1:0] clr_eff;

    assign clr_eff = clr_en ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst)
            flg_q <= '0;
        else
            flg_q <= (flg_q & ~clr_eff) | set_i;
    end

    assign flags_o = flg_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R10
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((flags_o & $past(clr_mask & ~set_i)) == '0)); // R10

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int PRESCALE = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       clk_sel,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] count_o,
    output logic [2:0]       flags_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    wr_dec_t               dec;
    logic                  tick_w;
    logic                  wrap_w;
    logic                  cmp_en_w;
    logic                  blk_w;
    logic [WIDTH-1:0]      cnt_w;
    logic [NUM_CH-1:0]     match_w;
    logic [NUM_FLAGS-1:0]  set_w;
    logic [NUM_FLAGS-1:0]  flg_w;

    assign dec = decode_write(wr_en, wr_addr);

    tmr_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .sel    (clk_sel),
        .tick_o (tick_w)
    );

    tmr_counter #(.W(WIDTH)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_w),
        .load      (dec.load_cnt),
        .load_val  (wr_data),
        .cnt_o     (cnt_w),
        .wrap_o    (wrap_w),
        .cmp_en_o  (cmp_en_w),
        .blocked_o (blk_w)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        tmr_compare #(.W(WIDTH)) u_cmp (
            .clk      (clk),
            .rst      (rst),
            .load     (dec.load_cmp[ch]),
            .load_val (wr_data),
            .cnt      (cnt_w),
            .cmp_en   (cmp_en_w),
            .match_o  (match_w[ch])
        );
    end

    assign set_w = {match_w, wrap_w};

    tmr_flags #(.N(NUM_FLAGS)) u_flg (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_w),
        .clr_en   (dec.clr),
        .clr_mask (wr_data[NUM_FLAGS-1:0]),
        .flags_o  (flg_w)
    );

    assign count_o = cnt_w;
    assign flags_o = flg_w;

    AST_NO_MATCH_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (tick_w && blk_w) |=> (!$rose(flags_o[1]) && !$rose(flags_o[2]))); // R8
    AST_WRAP_FLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_o[FLG_WRAP]) |-> ($past(count_o) == ALL_ONES)); // R5
    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == CS_STOP && !dec.load_cnt) |=> (count_o == $past(count_o))); // R2

endmodule

// File: tb/cmp_timer_test.sv
module cmp_timer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  clk_sel;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic [15:0] count_o;
    logic [2:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [15:0] cnt;
        logic [2:0]  flg;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];

    always #5 clk = ~clk;

    cmp_timer uut (
        .clk     (clk),
        .rst     (rst),
        .clk_sel (clk_sel),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .count_o (count_o),
        .flags_o (flags_o)
    );

    // driver side: queue an expected state for the current (negedge) moment
    task automatic expect_st(input string req, input logic [15:0] c, input logic [2:0] f);
        exp_t e;
        e.cnt = c;
        e.flg = f;
        exp_q.push_back(e);
        req_q.push_back(req);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t  e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                checks++;
                if (count_o !== e.cnt || flags_o !== e.flg) begin
                    errors++;
                    $display("FAIL %s: count=%h flags=%b expected count=%h flags=%b",
                             r, count_o, flags_o, e.cnt, e.flg);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; clk_sel = 2'd0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0;
        step(3);
        rst = 1'b0;
        expect_st("R1", 16'h0000, 3'b000);                 // R1 reset state

        wr(2'd1, 16'h0005);
        wr(2'd2, 16'h0020);
        step(5);
        expect_st("R2", 16'h0000, 3'b000);                 // R2 stopped

        clk_sel = 2'd1;
        step(3);
        expect_st("R3", 16'h0003, 3'b000);                 // R3 every cycle
        step(2);
        expect_st("R6", 16'h0005, 3'b000);
        step(1);
        expect_st("R6", 16'h0006, 3'b010);                 // R6 match A

        wr(2'd3, 16'h0002);
        expect_st("R10", 16'h0007, 3'b000);                // R10 clear

        clk_sel = 2'd0;
        step(1);
        wr(2'd0, 16'h0020);
        expect_st("R7", 16'h0020, 3'b000);
        step(4);
        expect_st("R9", 16'h0020, 3'b000);                 // R9 armed while stopped
        clk_sel = 2'd1;
        step(1);
        expect_st("R8", 16'h0021, 3'b000);                 // R8 loaded==B missed
        step(1);
        expect_st("R8", 16'h0022, 3'b000);

        wr(2'd0, 16'h001F);
        expect_st("R7", 16'h001F, 3'b000);                 // R7 load beats advance
        step(1);
        expect_st("R8", 16'h0020, 3'b000);
        step(1);
        expect_st("R8", 16'h0021, 3'b100);                 // R8 only one advance blocked

        wr(2'd3, 16'h0007);
        expect_st("R10", 16'h0022, 3'b000);

        wr(2'd0, 16'hFFFE);
        expect_st("R7", 16'hFFFE, 3'b000);
        step(1);
        expect_st("R5", 16'hFFFF, 3'b000);
        step(1);
        expect_st("R5", 16'h0000, 3'b001);                 // R5 wrap
        step(1);
        expect_st("R5", 16'h0001, 3'b001);

        wr(2'd0, 16'h0002);
        step(3);
        expect_st("R6", 16'h0005, 3'b001);
        wr(2'd3, 16'h0003);
        expect_st("R10", 16'h0006, 3'b010);                // R10 set wins

        wr(2'd3, 16'h0007);
        wr(2'd1, 16'h0012);
        wr(2'd0, 16'h0010);
        expect_st("R7", 16'h0010, 3'b000);
        clk_sel = 2'd2;
        step(8);
        expect_st("R4", 16'h0010, 3'b000);                 // R4 restart after change
        step(1);
        expect_st("R4", 16'h0011, 3'b000);
        step(7);
        expect_st("R4", 16'h0011, 3'b000);
        step(1);
        expect_st("R4", 16'h0012, 3'b000);
        step(7);
        expect_st("R6", 16'h0012, 3'b000);
        step(1);
        expect_st("R6", 16'h0013, 3'b010);                 // R6 under divide-by-8

        clk_sel = 2'd0;
        step(10);
        expect_st("R2", 16'h0013, 3'b010);

        step(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule